// File: doc/BRIEF.md
# PCIe Inbound BAR Window Decoder

This block sits behind the receive side of a PCI Express endpoint. For each inbound memory request it decides which Base Address Register window the 64-bit request address falls in. It then forms the 32-bit local byte address for the memory-mapped master port tied to that window. A window of 2^N bytes compares only the address bits from N upward against its programmed base. The low N bits go through unchanged as the offset. The bits above the offset are taken from the window's local base, which is set by parameter.

Six slots (index 0 to 5) exist. Each slot's enable, width (32-bit or 64-bit), prefetchable flag, size and local base are parameters. A 64-bit window uses slot i for the low half of its base and slot i+1 for the high half. System software writes the base registers through a small register port.

The result comes one cycle after the request: a hit flag, the winning slot index, a one-hot master select, the prefetchable flag and the translated address. A request that hits no window raises an unsupported-request flag instead. With the root-port parameter set, matching is skipped and every request goes to the single master 0.

Top module: `bar_xlate`

## Requirements
- R1: `rsp_valid` equals `req_valid` of the previous clock. When `req_valid` was low, `rsp_hit`, `rsp_ur` and `rsp_sel` are all zero.
- R2: A window of 2^N bytes hits when the request address, with bits N-1:0 cleared, equals its 64-bit base. Example: a 4 KB 64-bit window at base 0x0000123456789000 hits 0x0000123456789870 and misses 0x0000123456788FFF and 0x000012345678A000.
- R3: On a hit, `rsp_addr` keeps request bits N-1:0 of the winning window. Its upper bits come from that window's local base parameter, with the base's low N bits discarded.
- R4: A slot whose predecessor is an enabled 64-bit window holds the upper 32 base bits of that window and never reports a hit of its own.
- R5: When `req_is64` is 0, request bits 63:32 are treated as zero. A 32-bit window hits only requests whose bits 63:32 are zero.
- R6: A disabled slot never hits. Its register reads as zero and ignores writes.
- R7: When several windows hit, the one with the lowest slot index wins.
- R8: A valid request that hits no window gives `rsp_ur`=1, `rsp_hit`=0 and `rsp_sel`=0.
- R9: On a hit, `rsp_sel` has exactly one bit set, at position `rsp_bar`.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into slot `cfg_sel` (0 to 5). Bits below the window size are stored as zero. `cfg_rdata` shows slot `cfg_sel` combinationally.
- R11: With `ROOT_PORT`=1 every valid request hits, with `rsp_bar`=0, `rsp_sel`=1, `rsp_ur`=0 and `rsp_addr` equal to request bits 31:0.
- R12: After reset, all response flags are zero and every base register reads zero.
- R13: `rsp_pref` gives the prefetchable parameter bit of the winning window, and 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 3 | Slot addressed for write and readback |
| cfg_wdata | input | 32 | Base register write data |
| cfg_rdata | output | 32 | Base register readback |
| req_valid | input | 1 | Request valid |
| req_is64 | input | 1 | Request carries a 64-bit address |
| req_addr | input | 64 | Request byte address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | A window matched |
| rsp_ur | output | 1 | Unsupported request (no window matched) |
| rsp_bar | output | 3 | Winning slot index |
| rsp_sel | output | 6 | One-hot master port select |
| rsp_pref | output | 1 | Winning window is prefetchable |
| rsp_addr | output | 32 | Translated local byte address |

## Verification
The assertions check the cycle-level contract on every clock. This covers the one-cycle valid delay, hit and unsupported-request being exclusive, the one-hot select agreeing with the index, and the low offset bits passing through. It also covers that no upper-half or disabled slot is ever reported, and that root-port mode always hits. Which window should win, and the exact translated address, depend on the programmed bases and the address value. Only the bench's vectors show these: the 4 KB boundary on both sides, overlapping windows, zero extension of 32-bit requests, and masked register readback.

// File: rtl/bar_xlate.sv
module bar_xlate #(
  parameter int NUM_BAR = 6,
  parameter int LAW = 32,
  parameter bit ROOT_PORT = 1'b0,
  parameter logic [NUM_BAR-1:0] BAR_EN = 6'b101101,
  parameter logic [NUM_BAR-1:0] BAR_IS64 = 6'b000001,
  parameter logic [NUM_BAR-1:0] BAR_PREF = 6'b000001,
  parameter logic [NUM_BAR*8-1:0] BAR_LOG2 = {8'd8, 8'd12, 8'd20, 8'd16, 8'd12, 8'd12},
  parameter logic [NUM_BAR*LAW-1:0] LOCAL_BASE = {32'h5000_0000, 32'h0, 32'h3000_0000,
                                                  32'h2000_0000, 32'h0, 32'h1000_0000}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [((NUM_BAR>1)?$clog2(NUM_BAR):1)-1:0] cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic               req_is64,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_ur,
  output logic [((NUM_BAR>1)?$clog2(NUM_BAR):1)-1:0] rsp_bar,
  output logic [NUM_BAR-1:0] rsp_sel,
  output logic               rsp_pref,
  output logic [LAW-1:0]     rsp_addr
);
  localparam int SW = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1;

  logic [31:0]     base_q [NUM_BAR];
  logic [LAW-1:0]  xaddr  [NUM_BAR];
  logic [NUM_BAR-1:0] match, upper_v, live_v;
  logic [SW-1:0]   win;
  logic            any;
  logic [63:0]     addr64;

  assign addr64 = req_is64 ? req_addr : {32'd0, req_addr[31:0]};

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_slot
    localparam int PRV = (g + NUM_BAR - 1) % NUM_BAR;
    localparam int NXT = (g + 1) % NUM_BAR;
    localparam int N  = int'(BAR_LOG2[g*8 +: 8]);
    localparam int NP = int'(BAR_LOG2[PRV*8 +: 8]);
    localparam bit UP   = (g != 0) && BAR_EN[PRV] && BAR_IS64[PRV];
    localparam bit LIVE = BAR_EN[g] && !UP;
    localparam bit W64  = LIVE && BAR_IS64[g] && (g + 1 < NUM_BAR);
    localparam logic [63:0] AMASK = ~((64'd1 << N) - 64'd1);
    localparam logic [63:0] PMASK = ~((64'd1 << NP) - 64'd1);
    localparam logic [31:0] WMASK = UP ? PMASK[63:32] : (LIVE ? AMASK[31:0] : 32'd0);
    localparam logic [LAW-1:0] OMASK = ~AMASK[LAW-1:0];

    logic [63:0] base64;
    assign base64 = W64 ? {base_q[NXT], base_q[g]} : {32'd0, base_q[g]};
    assign match[g] = LIVE && ((addr64 & AMASK) == base64);
    assign xaddr[g] = (LOCAL_BASE[g*LAW +: LAW] & ~OMASK) | (addr64[LAW-1:0] & OMASK);
    assign upper_v[g] = UP;
    assign live_v[g]  = LIVE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[g] <= '0;
      else if (cfg_we && cfg_sel == SW'(g)) base_q[g] <= cfg_wdata & WMASK;
    end
  end

  assign cfg_rdata = (int'(cfg_sel) < NUM_BAR) ? base_q[cfg_sel] : 32'd0;
  assign any = |match;

  always_comb begin
    win = '0;
    for (int i = NUM_BAR - 1; i >= 0; i--)
      if (match[i]) win = SW'(i);
  end

  logic          nhit;
  logic [SW-1:0] nbar;
  assign nhit = req_valid && (ROOT_PORT || any);
  assign nbar = ROOT_PORT ? '0 : win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ur    <= 1'b0;
      rsp_bar   <= '0;
      rsp_sel   <= '0;
      rsp_pref  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= nhit;
      rsp_ur    <= req_valid && !ROOT_PORT && !any;
      rsp_bar   <= nbar;
      rsp_sel   <= nhit ? (NUM_BAR'(1) << nbar) : '0;
      rsp_pref  <= nhit && !ROOT_PORT && BAR_PREF[win];
      rsp_addr  <= ROOT_PORT ? addr64[LAW-1:0] : xaddr[win];
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_ur && rsp_sel == '0));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_ur));
  a_r8_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ur |-> rsp_sel == '0);
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($onehot(rsp_sel) && rsp_sel[rsp_bar]));
  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_addr[3:0] == $past(req_addr[3:0]));
  a_r4_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !ROOT_PORT) |-> !upper_v[rsp_bar]);
  a_r6_live_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !ROOT_PORT) |-> live_v[rsp_bar]);
  a_r11_root: assert property (@(posedge clk) disable iff (!rst_n)
    (ROOT_PORT && rsp_valid) |-> (rsp_hit && rsp_bar == '0));
endmodule

// File: tb/bar_xlate_tb.sv
module bar_xlate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_is64 = 1'b0;
  logic [63:0] req_addr = '0;

  logic [31:0] rdata, r_rdata;
  logic        v, hit, ur, pref, r_v, r_hit, r_ur, r_pref;
  logic [2:0]  bar, r_bar;
  logic [5:0]  sel, r_sel;
  logic [31:0] laddr, r_laddr;

  bar_xlate u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .req_valid(req_valid), .req_is64(req_is64),
    .req_addr(req_addr), .rsp_valid(v), .rsp_hit(hit), .rsp_ur(ur), .rsp_bar(bar),
    .rsp_sel(sel), .rsp_pref(pref), .rsp_addr(laddr));

  bar_xlate #(.ROOT_PORT(1'b1)) u_rp (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(r_rdata), .req_valid(req_valid),
    .req_is64(req_is64), .req_addr(req_addr), .rsp_valid(r_v), .rsp_hit(r_hit),
    .rsp_ur(r_ur), .rsp_bar(r_bar), .rsp_sel(r_sel), .rsp_pref(r_pref), .rsp_addr(r_laddr));

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string rq, input logic [2:0] s, input logic [31:0] exp);
    cfg_sel = s;
    #1;
    chk(rq, {32'd0, rdata}, {32'd0, exp});
  endtask

  // {req number, is64, address, expect hit, expect bar, expect local address}
  localparam int NV = 10;
  localparam logic [108:0] VEC [NV] = '{
    {8'd2, 1'b1, 64'h0000_1234_5678_9870, 1'b1, 3'd0, 32'h1000_0870}, // R2 R3 hit 4 KB
    {8'd2, 1'b1, 64'h0000_1234_5678_8FFF, 1'b0, 3'd0, 32'h0},         // R2 below window
    {8'd2, 1'b1, 64'h0000_1234_5678_A000, 1'b0, 3'd0, 32'h0},         // R2 above window
    {8'd4, 1'b1, 64'h0000_1235_5678_9000, 1'b0, 3'd0, 32'h0},         // R4 high half differs
    {8'd7, 1'b0, 64'h0000_0000_8000_1234, 1'b1, 3'd2, 32'h2000_1234}, // R7 overlap, slot 2 wins
    {8'd3, 1'b0, 64'h0000_0000_8008_0010, 1'b1, 3'd3, 32'h3008_0010}, // R3 1 MB offset
    {8'd5, 1'b1, 64'h0000_0001_8000_1234, 1'b0, 3'd0, 32'h0},         // R5 32-bit BAR, high bits set
    {8'd5, 1'b0, 64'hFFFF_FFFF_0000_0F42, 1'b1, 3'd5, 32'h5000_0042}, // R5 zero extension
    {8'd6, 1'b0, 64'h0000_0000_0000_0000, 1'b0, 3'd0, 32'h0},         // R6 disabled slot 4 at zero
    {8'd4, 1'b0, 64'h0000_0000_0000_1234, 1'b0, 3'd0, 32'h0}          // R4 upper slot no hit
  };

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", {63'd0, v}, 64'd0);
    chk("R12 hit/ur", {62'd0, hit, ur}, 64'd0);
    chk("R12 sel", {58'd0, sel}, 64'd0);
    rd("R12 base0", 3'd0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(3'd0, 32'h5678_9ABC);
    wr(3'd1, 32'h0000_1234);
    wr(3'd2, 32'h8000_FFFF);
    wr(3'd3, 32'h800F_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0000_0FAB);
    rd("R10 slot0 masked", 3'd0, 32'h5678_9000);
    rd("R10 slot1 upper", 3'd1, 32'h0000_1234);
    rd("R10 slot3 masked", 3'd3, 32'h8000_0000);
    rd("R10 slot5 masked", 3'd5, 32'h0000_0F00);
    rd("R6 disabled reads 0", 3'd4, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [108:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d vec%0d", e[108:101], i);
      @(negedge clk);
      req_valid = 1'b1; req_is64 = e[100]; req_addr = e[99:36];
      @(posedge clk);
      #1;
      chk({tg, " R1 valid"}, {63'd0, v}, 64'd1);
      chk({tg, " hit"}, {63'd0, hit}, {63'd0, e[35]});
      chk({tg, " R8 ur"}, {63'd0, ur}, {63'd0, !e[35]});
      chk({tg, " R9 sel"}, {58'd0, sel}, e[35] ? (64'd1 << e[34:32]) : 64'd0);
      chk({tg, " R13 pref"}, {63'd0, pref}, {63'd0, e[35] && e[34:32] == 3'd0});
      if (e[35]) begin
        chk({tg, " bar"}, {61'd0, bar}, {61'd0, e[34:32]});
        chk({tg, " R3 addr"}, {32'd0, laddr}, {32'd0, e[31:0]});
      end
    end

    // R11 root port forwards everything, R8 normal instance rejects it
    @(negedge clk);
    req_valid = 1'b1; req_is64 = 1'b1; req_addr = 64'h0000_0009_ABCD_0123;
    @(posedge clk);
    #1;
    chk("R11 hit", {62'd0, r_hit, r_ur}, 64'd2);
    chk("R11 bar/sel", {55'd0, r_bar, r_sel}, {55'd0, 3'd0, 6'd1});
    chk("R11 addr", {32'd0, r_laddr}, 64'hABCD_0123);
    chk("R8 miss ur", {62'd0, hit, ur}, 64'd1);
    chk("R8 miss sel", {58'd0, sel}, 64'd0);

    // R1 idle cycle
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 idle valid", {63'd0, v}, 64'd0);
    chk("R1 idle flags", {56'd0, hit, ur, sel}, 64'd0);

    // R6 write to disabled slot still ignored after traffic
    wr(3'd4, 32'h1234_5678);
    rd("R6 disabled after write", 3'd4, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule